// File: doc/BRIEF.md
# Streaming Configuration Image Header Parser

This block watches a configuration image as it streams past, one byte per accepted beat, and works out two numbers the loader needs before the payload arrives: the byte offset at which the payload begins and the payload length in bytes. It reads the header size and the record count from fixed places. It then walks a table of fixed-length records to find two offsets. Finally it skips forward to a table of packed 22-bit component sizes and adds them up, with each size counting for 16 bytes.

The parser makes one forward pass and never looks back. Every offset it must act on has to lie ahead of the byte it is currently reading, or the image is rejected. After reset it accepts bytes with `in_ready` high. It drops `in_ready` on the beat that completes the parse or reveals a fault. It then holds its results until the next reset. A new image is parsed after each reset.

Top module: `img_hdr_parser`

## Requirements
- R1: After reset `in_ready` is 1, `done` and `parse_err` are 0, and `payload_size` is 0.
- R2: The byte at offset 24 is the header size H. A value below 25 raises `parse_err` on the beat that carries offset 24.
- R3: The byte at offset H-1 is the record count N, and record 0 starts at offset H. A count of 0 raises `parse_err` on the beat that carries offset H-1.
- R4: A record is 9 bytes long. Byte +0 is an identifier, and bytes +1..+4 hold a little-endian 32-bit offset. The remaining bytes are ignored. Identifier 8 sets `payload_start` and identifier 5 sets the size table offset S. If an identifier repeats before the scan stops, the later record wins. All other identifiers are ignored.
- R5: The scan stops on the +4 byte of the record that makes both offsets known. Any further records are skipped unread, and the size table may begin on the very next byte.
- R6: If all N records pass without both offsets known, `parse_err` rises on the last byte of the last record.
- R7: The component count C is the little-endian 16-bit value at offsets 55..56. S must be at least 57 and must lie after the byte where the scan stopped, otherwise `parse_err` rises on the stopping byte.
- R8: Component i is bits 22i..22i+21 of the table, which is read as a bit stream with byte S bit 0 first. `payload_size` is 16 times the sum of all C components, modulo 2^32.
- R9: `done` rises on the beat that delivers the last bit of component C-1, so the last accepted offset is S + ceil(22C/8) - 1. With C = 0, `done` rises on the beat carrying offset S.
- R10: Once `done` or `parse_err` is set, `in_ready` is 0 and `done`, `parse_err`, `payload_start` and `payload_size` hold until reset. `done` and `parse_err` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Image byte present |
| in_data | input | 8 | Image byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| payload_start | output | 32 | Offset where the payload begins |
| payload_size | output | 32 | Payload length in bytes |
| done | output | 1 | Parse finished successfully |
| parse_err | output | 1 | Image rejected |

## Verification
Each internal fault shows up at the ports on a known beat. The bench therefore measures both the values and how many bytes were accepted before `in_ready` fell. A record-position counter that slips by one byte assembles the wrong offset. That either shifts the reported start or stops the scan on the wrong beat, and the accepted byte count changes at once. A bit-accumulator fault corrupts `payload_size` or moves the finishing beat by a byte. Image sweeps over component counts, header sizes and record orders, with irregular valid gaps, expose each of these faults as soon as that image completes.

// File: rtl/hdrp_pkg.sv
package hdrp_pkg;
  typedef enum logic [2:0] {
    ST_HDR,
    ST_REC,
    ST_SEEK,
    ST_SIZES,
    ST_FIN,
    ST_ERR
  } hdrp_state_e;
endpackage

// File: rtl/hdrp_lut_walk.sv
module hdrp_lut_walk #(
  parameter int REC_LEN = 9,
  parameter int OFF_W   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic [7:0]       byte_i,
  output logic             field_ok,
  output logic             rec_end,
  output logic [7:0]       rec_id,
  output logic [OFF_W-1:0] rec_start
);
  localparam int IDX_W = $clog2(REC_LEN);
  localparam int SB    = OFF_W / 8;

  logic [IDX_W-1:0] idx_q;
  logic [7:0]       id_q;
  logic [OFF_W-9:0] part_q;

  assign field_ok  = beat && (idx_q == IDX_W'(SB));
  assign rec_end   = beat && (idx_q == IDX_W'(REC_LEN - 1));
  assign rec_id    = id_q;
  assign rec_start = {byte_i, part_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      id_q   <= '0;
      part_q <= '0;
    end else if (beat) begin
      idx_q <= (idx_q == IDX_W'(REC_LEN - 1)) ? '0 : idx_q + 1'b1;
      if (idx_q == '0) id_q <= byte_i;
      for (int k = 1; k < SB; k++) begin
        if (idx_q == IDX_W'(k)) part_q[(k-1)*8 +: 8] <= byte_i;
      end
    end
  end

  // R4
  idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q < IDX_W'(REC_LEN));
endmodule

// File: rtl/hdrp_size_sum.sv
module hdrp_size_sum #(
  parameter int FW    = 22,
  parameter int SCALE = 16,
  parameter int SUM_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic [7:0]       byte_i,
  output logic             emit,
  output logic [CNT_W-1:0] nfield,
  output logic [SUM_W-1:0] sum
);
  localparam int ACC_W = FW + 8;
  localparam int BC_W  = $clog2(ACC_W + 1);
  localparam bit POW2  = (SCALE & (SCALE - 1)) == 0;
  localparam int SH    = $clog2(SCALE);

  logic [ACC_W-1:0] acc_q, acc_in;
  logic [BC_W-1:0]  nb_q, nb_in;
  logic [FW-1:0]    field;
  logic [SUM_W-1:0] scaled;

  assign acc_in = acc_q | (ACC_W'(byte_i) << nb_q);
  assign nb_in  = nb_q + BC_W'(8);
  assign emit   = beat && (nb_in >= BC_W'(FW));
  assign field  = acc_in[FW-1:0];

  generate
    if (POW2) begin : g_shift
      assign scaled = SUM_W'(field) << SH;
    end else begin : g_mul
      assign scaled = SUM_W'(field) * SUM_W'(SCALE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      nb_q   <= '0;
      sum    <= '0;
      nfield <= '0;
    end else if (beat) begin
      if (emit) begin
        acc_q  <= acc_in >> FW;
        nb_q   <= nb_in - BC_W'(FW);
        sum    <= sum + scaled;
        nfield <= nfield + 1'b1;
      end else begin
        acc_q <= acc_in;
        nb_q  <= nb_in;
      end
    end
  end

  // R8
  bits_held_chk: assert property (@(posedge clk) disable iff (rst)
    nb_q < BC_W'(FW));
endmodule

// File: rtl/img_hdr_parser.sv
module img_hdr_parser
  import hdrp_pkg::*;
#(
  parameter int          POS_W       = 32,
  parameter int          SUM_W       = 32,
  parameter int          CNT_W       = 16,
  parameter int          FIELD_W     = 22,
  parameter int          FRAME_BYTES = 16,
  parameter int          REC_BYTES   = 9,
  parameter int          OFF_HSIZE   = 24,
  parameter int          OFF_COUNT   = 55,
  parameter logic [7:0]  ID_PAYLOAD  = 8'd8,
  parameter logic [7:0]  ID_TABLE    = 8'd5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic [POS_W-1:0] payload_start,
  output logic [SUM_W-1:0] payload_size,
  output logic             done,
  output logic             parse_err
);
  localparam int         CNT_BYTES = CNT_W / 8;
  localparam int         MIN_TABLE = OFF_COUNT + CNT_BYTES;
  localparam logic [7:0] HS_MIN    = 8'(OFF_HSIZE + 1);

  hdrp_state_e      st_q;
  logic [POS_W-1:0] pos_q, p_q, s_q, s_now, rec_start;
  logic [7:0]       hs_q, hs_cur, nrec_q, rcnt_q, rec_id;
  logic [CNT_W-1:0] cnt_q, nfield;
  logic             pf_q, sf_q, rdy_q, done_q, err_q;
  logic             beat, rec_beat, tbl_beat, at_cnt;
  logic             field_ok, rec_end, hit_p, hit_s, both_now, table_ok;
  logic             emit, last_field;

  assign beat     = in_valid && rdy_q;
  assign rec_beat = beat && (st_q == ST_REC);
  assign tbl_beat = beat && ((st_q == ST_SIZES) ||
                    ((st_q == ST_SEEK) && (pos_q == s_q) && (cnt_q != '0)));

  assign hs_cur = (pos_q == POS_W'(OFF_HSIZE)) ? in_data : hs_q;
  assign at_cnt = (pos_q >= POS_W'(OFF_HSIZE)) &&
                  (pos_q == POS_W'(hs_cur) - POS_W'(1));

  hdrp_lut_walk #(.REC_LEN(REC_BYTES), .OFF_W(POS_W)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .beat     (rec_beat),
    .byte_i   (in_data),
    .field_ok (field_ok),
    .rec_end  (rec_end),
    .rec_id   (rec_id),
    .rec_start(rec_start)
  );

  hdrp_size_sum #(.FW(FIELD_W), .SCALE(FRAME_BYTES), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_sum (
    .clk   (clk),
    .rst   (rst),
    .beat  (tbl_beat),
    .byte_i(in_data),
    .emit  (emit),
    .nfield(nfield),
    .sum   (payload_size)
  );

  assign hit_p      = field_ok && (rec_id == ID_PAYLOAD);
  assign hit_s      = field_ok && (rec_id == ID_TABLE);
  assign s_now      = hit_s ? rec_start : s_q;
  assign both_now   = field_ok && (pf_q || hit_p) && (sf_q || hit_s);
  assign table_ok   = (s_now > pos_q) && (s_now >= POS_W'(MIN_TABLE));
  assign last_field = emit && (CNT_W'(nfield + 1'b1) == cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_HDR;
      pos_q  <= '0;
      hs_q   <= '0;
      nrec_q <= '0;
      rcnt_q <= '0;
      cnt_q  <= '0;
      p_q    <= '0;
      s_q    <= '0;
      pf_q   <= 1'b0;
      sf_q   <= 1'b0;
      rdy_q  <= 1'b1;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (beat) begin
      pos_q <= pos_q + 1'b1;
      for (int k = 0; k < CNT_BYTES; k++) begin
        if (pos_q == POS_W'(OFF_COUNT + k)) cnt_q[k*8 +: 8] <= in_data;
      end
      case (st_q)
        ST_HDR: begin
          if (pos_q == POS_W'(OFF_HSIZE)) hs_q <= in_data;
          if ((pos_q == POS_W'(OFF_HSIZE)) && (in_data < HS_MIN)) begin
            st_q <= ST_ERR; err_q <= 1'b1; rdy_q <= 1'b0;
          end else if (at_cnt) begin
            nrec_q <= in_data;
            if (in_data == 8'd0) begin
              st_q <= ST_ERR; err_q <= 1'b1; rdy_q <= 1'b0;
            end else begin
              st_q <= ST_REC;
            end
          end
        end
        ST_REC: begin
          if (hit_p) begin p_q <= rec_start; pf_q <= 1'b1; end
          if (hit_s) begin s_q <= rec_start; sf_q <= 1'b1; end
          if (both_now) begin
            if (table_ok) st_q <= ST_SEEK;
            else begin st_q <= ST_ERR; err_q <= 1'b1; rdy_q <= 1'b0; end
          end else if (rec_end) begin
            rcnt_q <= rcnt_q + 8'd1;
            if (8'(rcnt_q + 8'd1) == nrec_q) begin
              st_q <= ST_ERR; err_q <= 1'b1; rdy_q <= 1'b0;
            end
          end
        end
        ST_SEEK: begin
          if (pos_q == s_q) begin
            if (cnt_q == '0) begin
              st_q <= ST_FIN; done_q <= 1'b1; rdy_q <= 1'b0;
            end else begin
              st_q <= ST_SIZES;
            end
          end
        end
        ST_SIZES: begin
          if (last_field) begin
            st_q <= ST_FIN; done_q <= 1'b1; rdy_q <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign in_ready      = rdy_q;
  assign done          = done_q;
  assign parse_err     = err_q;
  assign payload_start = p_q;

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && parse_err));
  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done && !in_ready);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    parse_err |=> parse_err && !in_ready);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done || parse_err) |=> $stable(payload_size) && $stable(payload_start));
  // R9
  done_on_beat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(in_valid && in_ready));
  // R7
  table_after_count_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SIZES) |-> (pos_q > POS_W'(MIN_TABLE)));
endmodule

// File: tb/img_hdr_parser_test.sv
module img_hdr_parser_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready, done, parse_err;
  logic [31:0] payload_start, payload_size;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0]  img [0:1023];
  int unsigned sz [0:63];
  logic [31:0] rs = 32'h1234_5678;

  always #4 clk = ~clk;

  img_hdr_parser uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .payload_start(payload_start),
    .payload_size(payload_size), .done(done), .parse_err(parse_err)
  );

  function automatic logic [31:0] nxt(logic [31:0] v);
    logic [31:0] x = v;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  function automatic int tbl_len(int c);
    return (22 * c + 7) / 8;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 1024; i++) img[i] = 8'd0;
  endtask

  task automatic put32(input int at, input logic [31:0] v);
    for (int k = 0; k < 4; k++) img[at+k] = v[k*8 +: 8];
  endtask

  task automatic put_rec(input int at, input logic [7:0] id, input logic [31:0] off);
    img[at] = id;
    put32(at + 1, off);
  endtask

  task automatic put_count(input int c);
    img[55] = 8'(c);
    img[56] = 8'(c >> 8);
  endtask

  // R8: component i occupies table bits 22i..22i+21, byte S bit 0 first
  task automatic pack_sizes(input int s, input int c, output longint exp_sum);
    exp_sum = 0;
    for (int i = 0; i < c; i++) begin
      for (int b = 0; b < 22; b++) begin
        int p = 22 * i + b;
        img[s + p/8][p%8] = sz[i][b];
      end
      exp_sum = (exp_sum + 16 * longint'(sz[i])) % 64'h1_0000_0000;
    end
  endtask

  task automatic run_img(input int len, output int used);
    int i = 0;
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(in_ready === 1'b1, "R1 ready", longint'(in_ready), 1);
    chk(done === 1'b0 && parse_err === 1'b0, "R1 flags", longint'({done, parse_err}), 0);
    chk(payload_size === 32'd0, "R1 size", longint'(payload_size), 0);
    for (int cyc = 0; cyc < 4 * len + 50; cyc++) begin
      if (!in_ready || i >= len) break;
      rs = nxt(rs);
      in_valid = (rs[2:0] != 3'd0);
      in_data  = img[i];
      @(posedge clk);
      if (in_valid) i++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    used = i;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_ok(input string tag, input longint st, input longint sum, input int used, input int exp_used);
    logic [31:0] ps, pz;
    chk(done === 1'b1 && parse_err === 1'b0, {tag, " R9 done"}, longint'({done, parse_err}), 2);
    chk(payload_start === st[31:0], {tag, " R4 start"}, longint'(payload_start), st);
    chk(payload_size === sum[31:0], {tag, " R8 size"}, longint'(payload_size), sum);
    chk(used == exp_used, {tag, " R9 bytes"}, used, exp_used);
    ps = payload_start; pz = payload_size;
    in_valid = 1'b1; in_data = 8'hFF;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready === 1'b0 && payload_start === ps && payload_size === pz && done === 1'b1,
        {tag, " R10 hold"}, longint'(payload_size), longint'(pz));
  endtask

  task automatic expect_err(input string tag, input int used, input int exp_used);
    chk(parse_err === 1'b1 && done === 1'b0, {tag, " err flag"}, longint'({done, parse_err}), 1);
    chk(used == exp_used, {tag, " err byte"}, used, exp_used);
    chk(in_ready === 1'b0, {tag, " R10 ready"}, longint'(in_ready), 0);
  endtask

  initial begin
    int used;
    longint sum;
    // Sweep: C in 0..16, three header sizes, two record orders
    for (int c = 0; c <= 16; c++) begin
      for (int hs = 0; hs < 3; hs++) begin
        for (int ord = 0; ord < 2; ord++) begin
          int h = (hs == 0) ? 26 : (hs == 1) ? 40 : 70;
          int s = ((h + 27 > 57) ? h + 27 : 57) + (c % 3);
          int p = s + tbl_len(c) + (c % 4);
          clear_img();
          img[24] = 8'(h);
          img[h-1] = 8'd3;
          put_rec(h, 8'd3, 32'h0000_0011);
          put_rec(h + 9,  ord ? 8'd5 : 8'd8, ord ? 32'(s) : 32'(p));
          put_rec(h + 18, ord ? 8'd8 : 8'd5, ord ? 32'(p) : 32'(s));
          for (int i = 0; i < c; i++) begin
            rs = nxt(rs);
            sz[i] = ((c + i) % 5 == 0) ? 32'h3F_FFFF :
                    ((c + i) % 7 == 0) ? 32'd0 : {10'd0, rs[21:0]};
          end
          put_count(c);
          pack_sizes(s, c, sum);
          run_img(s + tbl_len(c) + 8, used);
          expect_ok("R4 R8 sweep", p, sum, used, (c == 0) ? s + 1 : s + tbl_len(c));
        end
      end
    end

    // R5: table starts right after the stopping byte
    clear_img();
    img[24] = 8'd60; img[59] = 8'd5;
    put_rec(60, 8'd5, 32'd74);
    put_rec(69, 8'd8, 32'd500);
    sz[0] = 32'd1; sz[1] = 32'h20_0000; sz[2] = 32'd12345;
    put_count(3);
    pack_sizes(74, 3, sum);
    run_img(100, used);
    expect_ok("R5 early stop", 500, sum, used, 74 + tbl_len(3));

    // R4: repeated identifier, later one wins; count bytes inside an ignored tail
    clear_img();
    img[24] = 8'd30; img[29] = 8'd3;
    put_rec(30, 8'd8, 32'd100);
    put_rec(39, 8'd8, 32'd200);
    put_rec(48, 8'd5, 32'd80);
    sz[0] = 32'd7; sz[1] = 32'd9;
    put_count(2);
    pack_sizes(80, 2, sum);
    run_img(120, used);
    expect_ok("R4 repeat", 200, sum, used, 80 + tbl_len(2));

    // R2/R3: header size 25 makes byte 24 also the record count
    clear_img();
    img[24] = 8'd25;
    put_rec(25, 8'd8, 32'd300);
    put_rec(34, 8'd5, 32'd60);
    put_count(1);
    sz[0] = 32'h2A_AAAA;
    pack_sizes(60, 1, sum);
    run_img(120, used);
    expect_ok("R2 R3 min header", 300, sum, used, 60 + tbl_len(1));

    // R8: many maximal components
    clear_img();
    img[24] = 8'd30; img[29] = 8'd2;
    put_rec(30, 8'd5, 32'd64);
    put_rec(39, 8'd8, 32'd400);
    for (int i = 0; i < 40; i++) sz[i] = 32'h3F_FFFF;
    put_count(40);
    pack_sizes(64, 40, sum);
    run_img(300, used);
    expect_ok("R8 max", 400, sum, used, 64 + tbl_len(40));

    // R2: header size too small
    clear_img();
    img[24] = 8'd20;
    run_img(80, used);
    expect_err("R2 small header", used, 25);

    // R3: zero records
    clear_img();
    img[24] = 8'd30; img[29] = 8'd0;
    run_img(80, used);
    expect_err("R3 no records", used, 30);

    // R6: table offset never found
    clear_img();
    img[24] = 8'd30; img[29] = 8'd2;
    put_rec(30, 8'd8, 32'd200);
    put_rec(39, 8'd3, 32'd90);
    run_img(120, used);
    expect_err("R6 missing", used, 48);

    // R7: table below the count field
    clear_img();
    img[24] = 8'd26; img[25] = 8'd2;
    put_rec(26, 8'd8, 32'd200);
    put_rec(35, 8'd5, 32'd50);
    run_img(120, used);
    expect_err("R7 low table", used, 40);

    // R7: table behind the stopping byte
    clear_img();
    img[24] = 8'd60; img[59] = 8'd2;
    put_rec(60, 8'd5, 32'd61);
    put_rec(69, 8'd8, 32'd200);
    run_img(120, used);
    expect_err("R7 behind", used, 74);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule